// File: doc/BRIEF.md
# Streaming 3x3 Median Filter

This block takes a stream of three-sample columns, one per clock when `inValid` is high, and keeps the three most recent accepted columns as a 3x3 window. For each new window it reports the median of the nine samples. It does not sort. It keeps a matrix of pairwise "ranks below" bits between window members. When a column arrives, the bits among the six samples that stay are carried over. Fresh bits are computed only for the three arriving samples, each against the six that stay and against the other two arrivals.

A sample's rank is the number of members that rank below it. The sample with rank 4 (zero-based) is the median. Equal values are ordered by a fixed rule: the sample that entered earlier counts as smaller, and within one column the lower row counts as smaller. Because of this rule the nine ranks always form a permutation of 0..8, so exactly one sample has rank 4.

Forming columns from a raster and handling image borders are the job of the surrounding logic.

Top module: `medfilt3x3`

## Requirements
- R1: Each accepted column (`inValid` high at a rising edge) becomes the newest column of the window, and the oldest column is dropped. Row r of `colIn` sits at bits [r*W +: W].
- R2: A column presented with `inValid` low leaves the window unchanged and produces no output.
- R3: After reset, `outValid` stays low for the first two accepted columns. It is first raised for the third accepted column.
- R4: A column captured at rising edge k yields `outValid` high, together with its median, from rising edge k+1. `outValid` is a single-cycle pulse per accepted column once the window is full.
- R5: `medOut` equals the fifth smallest (zero-based rank 4) of the nine samples in the window formed by the last three accepted columns.
- R6: Ties are ordered by age, then by row. Windows that contain repeated values still produce exactly one rank-4 sample, and the correct median value.
- R7: While `outValid` is low, `medOut` holds its last value.
- R8: A synchronous active-high `rst` clears `outValid`, sets `medOut` to 0, empties the fill count and zeroes the window.
- R9: Samples are unsigned and cover the full range 0 to 2^W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Qualifies `colIn` for this cycle |
| colIn | input | 3*SAMPLE_W | Column of three samples, row 0 in the low bits |
| outValid | output | 1 | One-cycle strobe marking a new median |
| medOut | output | SAMPLE_W | Median of the current window |

## Verification
The bench builds the filter with its default 8-bit samples. This makes the extremes 0 and 255 easy to drive, and long runs of equal values stress the tie ordering. A small-alphabet pseudo-random stream produces windows that are almost all ties. A full-range stream with bubbles in `inValid` checks the window shift, the one-edge output delay and the hold of `medOut` against a sort-based model. A reset in the middle of a stream shows that the three-column fill starts over.

// File: rtl/medfilt_pkg.sv
package medfilt_pkg;
  localparam int ROWS  = 3;
  localparam int COLS  = 3;
  localparam int SLOTS = ROWS * COLS;
  localparam int MID   = SLOTS / 2;
  localparam int RW    = $clog2(SLOTS);

  typedef struct packed {
    logic shiftEn;  // accept the column on this edge
    logic fire;     // window was completed on the previous edge
  } medStrobe_t;
endpackage

// File: rtl/medfilt_ctrl.sv
module medfilt_ctrl
  import medfilt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output medStrobe_t strobe
);
  localparam int CW = $clog2(COLS);
  localparam logic [CW-1:0] FULL_M1 = CW'(COLS - 1);

  logic [CW-1:0] fillCnt;
  logic          fireQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt <= '0;
      fireQ   <= 1'b0;
    end else begin
      fireQ <= inValid && (fillCnt == FULL_M1);
      if (inValid && (fillCnt != FULL_M1))
        fillCnt <= fillCnt + 1'b1;
    end
  end

  assign strobe.shiftEn = inValid;
  assign strobe.fire    = fireQ;

  // R3: the fill count only grows between resets and never passes its cap
  a_r3_fill_monotonic: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> fillCnt >= $past(fillCnt));
  a_r3_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fillCnt <= FULL_M1);
endmodule

// File: rtl/medfilt_window.sv
module medfilt_window
  import medfilt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shiftEn,
  input  logic [ROWS*W-1:0]      colIn,
  output logic [SLOTS*W-1:0]     winFlat,
  output logic [SLOTS*SLOTS-1:0] ltMat
);
  localparam int NEW0 = SLOTS - ROWS;

  // Slot order equals tie order: older column first, then lower row.
  function automatic logic [SLOTS*SLOTS-1:0] initOrder();
    logic [SLOTS*SLOTS-1:0] m;
    m = '0;
    for (int i = 0; i < SLOTS; i++)
      for (int j = 0; j < SLOTS; j++)
        if (i < j) m[i*SLOTS + j] = 1'b1;
    return m;
  endfunction

  localparam logic [SLOTS*SLOTS-1:0] RESET_LT = initOrder();

  logic [SLOTS*W-1:0]     nextWin;
  logic [SLOTS*SLOTS-1:0] nextLt;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s < NEW0) begin : g_keep
      assign nextWin[s*W +: W] = winFlat[(s+ROWS)*W +: W];
    end else begin : g_new
      assign nextWin[s*W +: W] = colIn[(s-NEW0)*W +: W];
    end
  end

  // ltMat[i*SLOTS+j] set means slot i ranks below slot j
  for (genvar i = 0; i < SLOTS; i++) begin : g_row
    for (genvar j = 0; j < SLOTS; j++) begin : g_col
      if (i == j) begin : g_diag
        assign nextLt[i*SLOTS + j] = 1'b0;
      end else if (i < NEW0 && j < NEW0) begin : g_reuse
        assign nextLt[i*SLOTS + j] = ltMat[(i+ROWS)*SLOTS + (j+ROWS)];
      end else if (i < j) begin : g_earlier
        assign nextLt[i*SLOTS + j] = nextWin[i*W +: W] <= nextWin[j*W +: W];
      end else begin : g_later
        assign nextLt[i*SLOTS + j] = nextWin[i*W +: W] < nextWin[j*W +: W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      winFlat <= '0;
      ltMat   <= RESET_LT;
    end else if (shiftEn) begin
      winFlat <= nextWin;
      ltMat   <= nextLt;
    end
  end

  // R6: every pair is strictly ordered one way
  for (genvar a = 0; a < SLOTS; a++) begin : g_as
    for (genvar b = a + 1; b < SLOTS; b++) begin : g_bs
      a_r6_antisym: assert property (@(posedge clk) disable iff (rst)
        ltMat[a*SLOTS + b] != ltMat[b*SLOTS + a]);
    end
  end

  // R2: nothing moves without an accepted column
  a_r2_hold_window: assert property (@(posedge clk) disable iff (rst)
    !shiftEn |=> ($stable(winFlat) && $stable(ltMat)));
endmodule

// File: rtl/medfilt_select.sv
module medfilt_select
  import medfilt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fire,
  input  logic [SLOTS*W-1:0]     winFlat,
  input  logic [SLOTS*SLOTS-1:0] ltMat,
  output logic                   outValid,
  output logic [W-1:0]           medOut
);
  logic [SLOTS-1:0] selVec;
  logic [W-1:0]     medNext;

  for (genvar j = 0; j < SLOTS; j++) begin : g_rank
    logic [RW-1:0] rnk;
    always_comb begin
      rnk = '0;
      for (int i = 0; i < SLOTS; i++)
        rnk = rnk + RW'(ltMat[i*SLOTS + j]);
    end
    assign selVec[j] = (rnk == RW'(MID));
  end

  always_comb begin
    medNext = '0;
    for (int j = 0; j < SLOTS; j++)
      if (selVec[j]) medNext = medNext | winFlat[j*W +: W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      medOut   <= '0;
    end else begin
      outValid <= fire;
      if (fire) medOut <= medNext;
    end
  end

  // R6: exactly one member holds the middle rank
  a_r6_single_median: assert property (@(posedge clk) disable iff (rst)
    $onehot(selVec));
  // R7: output holds without a new window
  a_r7_hold_median: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(medOut));
endmodule

// File: rtl/medfilt3x3.sv
module medfilt3x3
  import medfilt_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inValid,
  input  logic [3*SAMPLE_W-1:0] colIn,
  output logic                  outValid,
  output logic [SAMPLE_W-1:0]   medOut
);
  medStrobe_t             strobe;
  logic [SLOTS*SAMPLE_W-1:0] winFlat;
  logic [SLOTS*SLOTS-1:0]    ltMat;

  medfilt_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobe  (strobe)
  );

  medfilt_window #(.W(SAMPLE_W)) window_i (
    .clk     (clk),
    .rst     (rst),
    .shiftEn (strobe.shiftEn),
    .colIn   (colIn),
    .winFlat (winFlat),
    .ltMat   (ltMat)
  );

  medfilt_select #(.W(SAMPLE_W)) select_i (
    .clk      (clk),
    .rst      (rst),
    .fire     (strobe.fire),
    .winFlat  (winFlat),
    .ltMat    (ltMat),
    .outValid (outValid),
    .medOut   (medOut)
  );

  // R4: a median strobe always traces back to a column two edges earlier
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 2));
endmodule

// File: tb/medfilt3x3_tb_top.sv
module medfilt3x3_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int N_STIM = 18;

  // {valid, row2, row1, row0}
  localparam logic [24:0] STIM [N_STIM] = '{
    25'h1_030201, 25'h1_060504, 25'h1_090807, 25'h0_FFFFFF,
    25'h1_0A0B0C, 25'h1_000000, 25'h0_121212, 25'h1_FFFFFF,
    25'h1_808080, 25'h1_7F0181, 25'h1_05FF00, 25'h0_000000,
    25'h1_200010, 25'h1_FF40FF, 25'h1_3C3C3C, 25'h1_01FE02,
    25'h0_AAAAAA, 25'h1_102030
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [3*W-1:0] colIn = '0;
  logic outValid;
  logic [W-1:0] medOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  logic [W-1:0] mw [9];
  int   mFill;
  logic d1Valid, d2Valid;
  logic [W-1:0] d1Med, d2Med, lastMed;
  logic [31:0] lfsr = 32'h1ACE_5EED;

  always #(CLK_PERIOD/2) clk = ~clk;

  medfilt3x3 #(.SAMPLE_W(W)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .colIn(colIn),
    .outValid(outValid), .medOut(medOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] refMedian();
    logic [W-1:0] a [9];
    logic [W-1:0] t;
    for (int k = 0; k < 9; k++) a[k] = mw[k];
    for (int p = 0; p < 9; p++)
      for (int q = 0; q < 8 - p; q++)
        if (a[q] > a[q+1]) begin t = a[q]; a[q] = a[q+1]; a[q+1] = t; end
    return a[4];
  endfunction

  task automatic modelClear();
    for (int k = 0; k < 9; k++) mw[k] = '0;
    mFill = 0; d1Valid = 0; d2Valid = 0; d1Med = '0; d2Med = '0; lastMed = '0;
  endtask

  // One cycle: check the outputs, then present the next column.
  task automatic step(input logic v, input logic [3*W-1:0] col, input string medTag);
    @(negedge clk);
    check(outValid === d2Valid, "R3 R4 outValid", int'(outValid), int'(d2Valid));
    if (d2Valid) begin
      check(medOut === d2Med, medTag, int'(medOut), int'(d2Med));
      lastMed = d2Med;
    end else begin
      check(medOut === lastMed, "R7 hold", int'(medOut), int'(lastMed));
    end
    d2Valid = d1Valid; d2Med = d1Med;
    inValid = v; colIn = col;
    if (v) begin
      for (int k = 0; k < 6; k++) mw[k] = mw[k+3];
      for (int r = 0; r < 3; r++) mw[6+r] = col[r*W +: W];
      if (mFill < 3) mFill++;
    end
    d1Valid = v && (mFill >= 3);
    d1Med = refMedian();
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; colIn = '0;
    repeat (2) @(negedge clk);
    // R8: outputs cleared while reset is held
    check(outValid === 1'b0, "R8 reset outValid", int'(outValid), 0);
    check(medOut === '0, "R8 reset medOut", int'(medOut), 0);
    rst = 1'b0;
    modelClear();
  endtask

  task automatic lfsrStep();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  initial begin
    modelClear();
    doReset();

    // Table walk: R1 sliding window, R2 bubbles, R9 extremes
    for (int n = 0; n < N_STIM; n++)
      step(STIM[n][24], STIM[n][23:0], "R1 R2 R5 R9 median");
    repeat (3) step(1'b0, '0, "R7 drain");

    // R6: all-equal and heavy-tie windows
    doReset();
    step(1'b1, 24'h050505, "R6 tie median");
    step(1'b1, 24'h050505, "R6 tie median");
    step(1'b1, 24'h050505, "R6 tie median");
    step(1'b1, 24'h070505, "R6 tie median");
    step(1'b1, 24'h050705, "R6 tie median");
    step(1'b1, 24'h030303, "R6 tie median");
    step(1'b0, '0, "R6 tie median");
    step(1'b0, '0, "R6 tie median");

    // R3: reset mid-stream restarts the fill
    step(1'b1, 24'h112233, "R3 refill");
    step(1'b1, 24'h445566, "R3 refill");
    doReset();
    step(1'b1, 24'h010101, "R3 refill");
    step(1'b1, 24'h020202, "R3 refill");
    step(1'b1, 24'h030303, "R3 refill");
    step(1'b0, '0, "R3 refill");
    step(1'b0, '0, "R3 refill");

    // R6: small alphabet, almost every window has ties
    for (int n = 0; n < 300; n++) begin
      logic [3*W-1:0] c;
      lfsrStep();
      c = {6'd0, lfsr[5:4], 6'd0, lfsr[3:2], 6'd0, lfsr[1:0]};
      step(lfsr[7:6] != 2'b00, c, "R5 R6 tie stream");
    end

    // R9: full-range stream with bubbles
    for (int n = 0; n < 400; n++) begin
      logic [3*W-1:0] c;
      lfsrStep();
      c = lfsr[23:0];
      lfsrStep();
      step(lfsr[2:0] != 3'b000, c, "R1 R5 R9 wide stream");
    end
    repeat (3) step(1'b0, '0, "R7 drain");

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule